// File: doc/BRIEF.md
# Real-Time-Clock Timebase with Stop Control

This block keeps wall-clock time from a 32.768 kHz clock. A 15-stage binary prescaler divides the clock down. The 0-to-1 transition of its top stage produces a one-cycle second tick. That tick advances three cascaded BCD fields: seconds, minutes and hours in 24-hour form.

A stop input freezes timekeeping. While stop is high, the two lowest prescaler stages keep counting freely. The thirteen upper stages are held at zero, and software may load any time field through a small load port. The upper stages restart from zero when stop is released, so the first second after release is a short, well-defined interval of about half a second. After that, the tick arrives once every 32768 clocks.

An active-low oscillator-stopped reset clears every register asynchronously and blocks all loads while it is held.

Top module: `rtc_timebase`

## Requirements
- R1: While `osc_rst_n` is low, hours, minutes, seconds and the whole prescaler are zero, and a load strobe has no effect.
- R2: With `stop` high, a one-cycle `wr_en` stores `wr_data` into the field chosen by `wr_sel` (0 = seconds, 1 = minutes, 2 = hours), visible after the next clock edge. The other fields are unchanged.
- R3: A load strobe while `stop` is low is ignored: the time outputs keep their value.
- R4: While `stop` is high and no load occurs, the time outputs hold. Prescaler stages 2 to 14 read zero one edge after `stop` is seen, and stages 0 and 1 keep counting.
- R5: Counting clock edges from the first edge that samples `stop` low, the first time increment lands on edge 16381, 16382, 16383 or 16384. The exact edge depends on the free stages.
- R6: Every later increment lands exactly 32768 edges after the previous one.
- R7: `tick` is high for exactly the one cycle that precedes the edge where the time advances. That edge is the 0-to-1 transition of stage 14.
- R8: Seconds count in BCD (for example 09 to 10). They wrap from 59 to 00 and carry one into minutes.
- R9: Minutes count in BCD, wrap from 59 to 00, and carry one into hours.
- R10: Hours count in BCD, 24-hour form, and wrap from 23 to 00, so 23:59:59 is followed by 00:00:00.
- R11: If `stop` is high in the cycle where the prescaler would produce a tick, no increment happens and the time is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timebase clock |
| osc_rst_n | input | 1 | Oscillator-stopped reset, active low, asynchronous |
| stop | input | 1 | Freeze timekeeping and hold upper prescaler stages at zero |
| wr_en | input | 1 | One-cycle load strobe for a time field |
| wr_sel | input | 2 | Field select: 0 seconds, 1 minutes, 2 hours |
| wr_data | input | 8 | BCD value to load |
| tick | output | 1 | One-cycle second pulse |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours, BCD, 24-hour |

## Verification
The collision that matters is the stop request landing in the very cycle the prescaler reaches its tick point. The bench measures the exact 32768-edge period from one observed increment and raises `stop` on the final cycle of the next period. It then judges that no increment occurred and that the time stays frozen afterwards. The second collision is a load strobe arriving while the clock runs. The bench drives that strobe just after a tick and judges that the time outputs did not move.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 3;
  localparam int FIELD_W    = 8;

  // Limit value of each BCD field: 59 for seconds/minutes, 23 for hours.
  function automatic logic [FIELD_W-1:0] field_limit(input int idx);
    return (idx == NUM_FIELDS - 1) ? 8'h23 : 8'h59;
  endfunction

  // One BCD step with wrap to zero at or beyond the limit.
  function automatic logic [FIELD_W-1:0] bcd_step(input logic [FIELD_W-1:0] v,
                                                  input logic [FIELD_W-1:0] limit);
    if (v >= limit)        return '0;
    else if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                   return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int STAGES = 15,
  parameter int FREE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  output logic [STAGES-1:0] cnt_o,
  output logic              rise_o
);
  localparam int UP_W = STAGES - FREE;

  logic [FREE-1:0] low_q;
  logic [UP_W-1:0] up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      up_q  <= '0;
    end else begin
      low_q <= low_q + 1'b1;
      if (stop)          up_q <= '0;
      else if (&low_q)   up_q <= up_q + 1'b1;
    end
  end

  assign cnt_o  = {up_q, low_q};
  // Next edge moves the top stage from 0 to 1.
  assign rise_o = !stop && (&cnt_o[STAGES-2:0]) && !cnt_o[STAGES-1];
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [FIELD_W-1:0] LIMIT = 8'h59
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               ld,
  input  logic [FIELD_W-1:0] ld_val,
  output logic [FIELD_W-1:0] val,
  output logic               carry
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= '0;
    else if (ld)   val <= ld_val;
    else if (inc)  val <= bcd_step(val, LIMIT);
  end

  assign carry = inc && (val >= LIMIT);
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int FREE   = 2
) (
  input  logic       clk,
  input  logic       osc_rst_n,
  input  logic       stop,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic       tick,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour
);
  logic [STAGES-1:0]  pre_q;
  logic               sec_tick;
  logic [FIELD_W-1:0] fval   [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] finc, fcarry, fld;

  rtc_prescaler #(.STAGES(STAGES), .FREE(FREE)) u_pre (
    .clk    (clk),
    .rst_n  (osc_rst_n),
    .stop   (stop),
    .cnt_o  (pre_q),
    .rise_o (sec_tick)
  );

  assign finc[0] = sec_tick;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    if (i > 0) begin : g_chain
      assign finc[i] = fcarry[i-1];
    end
    assign fld[i] = wr_en && stop && (wr_sel == i[1:0]);
    rtc_bcd_field #(.LIMIT(field_limit(i))) u_fld (
      .clk    (clk),
      .rst_n  (osc_rst_n),
      .inc    (finc[i]),
      .ld     (fld[i]),
      .ld_val (wr_data),
      .val    (fval[i]),
      .carry  (fcarry[i])
    );
  end

  assign tick = sec_tick;
  assign sec  = fval[0];
  assign min  = fval[1];
  assign hour = fval[2];
endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk #(
  parameter int STAGES = 15,
  parameter int FREE   = 2
) (
  input logic              clk,
  input logic              osc_rst_n,
  input logic              stop,
  input logic              wr_en,
  input logic              tick,
  input logic [STAGES-1:0] pre_q,
  input logic [7:0]        sec,
  input logic [7:0]        min,
  input logic [7:0]        hour
);
  logic [23:0] now;
  assign now = {hour, min, sec};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !osc_rst_n |-> (now == 24'h0 && pre_q == '0)); // R1

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!osc_rst_n)
    (stop && !wr_en) |=> $stable(now)); // R4

  AST_STOP_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!osc_rst_n)
    stop |=> (pre_q[STAGES-1:FREE] == '0)); // R4

  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!osc_rst_n)
    tick |=> (pre_q[STAGES-1] && pre_q[STAGES-2:0] == '0)); // R7

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!osc_rst_n)
    (!tick && !(stop && wr_en)) |=> $stable(now)); // R3

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!osc_rst_n)
    (tick && sec == 8'h59) |=> (sec == 8'h00)); // R8

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!osc_rst_n)
    (tick && now == 24'h235959) |=> (now == 24'h0)); // R10
endmodule

bind rtc_timebase rtc_timebase_chk #(.STAGES(STAGES), .FREE(FREE)) u_chk (
  .clk       (clk),
  .osc_rst_n (osc_rst_n),
  .stop      (stop),
  .wr_en     (wr_en),
  .tick      (tick),
  .pre_q     (pre_q),
  .sec       (sec),
  .min       (min),
  .hour      (hour)
);

// File: tb/tb_rtc_timebase.sv
module tb_rtc_timebase;
  logic       clk = 1'b0;
  logic       osc_rst_n;
  logic       stop;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       tick;
  logic [7:0] sec, min, hour;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_timebase dut (
    .clk(clk), .osc_rst_n(osc_rst_n), .stop(stop), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .tick(tick),
    .sec(sec), .min(min), .hour(hour)
  );

  localparam int NV = 5;
  localparam logic [23:0] VEC_LOAD [NV] = '{24'h000059, 24'h005959, 24'h235959,
                                            24'h124512, 24'h090909};
  localparam logic [23:0] VEC_EXP  [NV] = '{24'h000100, 24'h010000, 24'h000000,
                                            24'h124513, 24'h090910};

  function automatic logic [23:0] now();
    return {hour, min, sec};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Counts edges until the time outputs change; reports tick seen just before.
  task automatic wait_change(output int n, output bit tk);
    logic [23:0] prev;
    prev = now();
    n = 0; tk = 1'b0;
    while (n < 40000) begin
      tk = tick;
      @(posedge clk);
      n++;
      @(negedge clk);
      if (now() != prev) break;
    end
  endtask

  initial begin
    int n;
    bit tk;
    osc_rst_n = 1'b0; stop = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(now() == 24'h0, "R1 reset time", now(), 0);
    load(2'd0, 8'h42);
    check(now() == 24'h0, "R1 load ignored in reset", now(), 0);
    osc_rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      stop = 1'b1;
      @(negedge clk);
      load(2'd2, VEC_LOAD[i][23:16]);
      load(2'd1, VEC_LOAD[i][15:8]);
      load(2'd0, VEC_LOAD[i][7:0]);
      check(now() == VEC_LOAD[i], "R2 load", now(), VEC_LOAD[i]);
      repeat (5) @(negedge clk);
      check(now() == VEC_LOAD[i], "R4 frozen", now(), VEC_LOAD[i]);
      stop = 1'b0;
      wait_change(n, tk);
      check(n >= 16381 && n <= 16384, "R5 first increment edge", n, 16384);
      check(tk, "R7 tick before increment", tk, 1);
      check(now() == VEC_EXP[i], "R8/R9/R10 advanced time", now(), VEC_EXP[i]);
    end

    // R6 exact period
    wait_change(n, tk);
    check(n == 32768, "R6 period", n, 32768);
    check(now() == 24'h090911, "R8 BCD step", now(), 24'h090911);

    // R3 load while running
    load(2'd0, 8'h45);
    check(now() == 24'h090911, "R3 load while running", now(), 24'h090911);

    // R11 stop raised on the tick cycle (one edge already used by the load)
    repeat (32766) @(negedge clk);
    check(tick == 1'b1, "R7 tick due", tick, 1);
    stop = 1'b1;
    repeat (3) @(negedge clk);
    check(now() == 24'h090911, "R11 tick suppressed", now(), 24'h090911);
    repeat (100) @(negedge clk);
    check(now() == 24'h090911, "R4 stays frozen", now(), 24'h090911);
    load(2'd0, 8'h30);
    check(now() == 24'h090930, "R2 seconds only", now(), 24'h090930);
    stop = 1'b0;
    wait_change(n, tk);
    check(n >= 16381 && n <= 16384, "R5 release after suppress", n, 16384);
    check(now() == 24'h090931, "R8 after release", now(), 24'h090931);

    // R1 reset mid-run
    osc_rst_n = 1'b0;
    #1;
    check(now() == 24'h0, "R1 async clear", now(), 0);
    @(negedge clk);
    osc_rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(now() == 24'h0, "R1 stays zero after reset", now(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_950_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule